// File: doc/BRIEF.md
# Flash Embedded Operation Controller

This block is the internal sequencer of a NOR-style flash array. A command front end, which has already decoded the unlock sequence, hands it program, sector-erase, chip-erase, erase-suspend and erase-resume requests. The block then runs the operation by itself. A program request writes and verifies one word. An erase request first preprograms every targeted word that is not already zero, then runs a timed erase pulse, then forces the selected sectors to all ones, then verifies. When the operation finishes, the block returns to array-read mode with no host action.

While an operation runs, host reads return a status word instead of array data. The status word carries a data-poll bit and a toggle bit, and an active-low ready/busy output runs alongside it. A parameterised cycle counter stands in for the analog pulse timers. The cell array is a small synchronous register file, sectored on the upper address bits. Per-sector protection, a temporary-unprotect override and a low-supply inhibit decide whether a request starts at all. An erase can be suspended, which lets other sectors be read, and can later be resumed.

Top module: `flash_op_engine`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `readyN` is 1 and reads return stored array data.
- R2: A program request (`cmdOp`=1) performs stored = stored AND `cmdData` at `cmdAddr`. `readyN` is 0 for exactly PROG_CYC+2 cycles, starting in the cycle after acceptance.
- R3: A sector erase (`cmdOp`=2) sets every word of each selected sector to all ones and leaves all other sectors unchanged. The sector of an address is its top log2(SECT_N) bits, and bit i of `cmdSectMask` selects sector i. `readyN` is 0 for exactly 2^ADDR_W+ERASE_CYC+2 cycles, because the preprogram pass scans the whole address space.
- R4: A chip erase (`cmdOp`=3) acts as a sector erase with every sector selected.
- R5: A read accepted while busy returns a status word. Bit 7 is the complement of the programmed data's bit 7 during a program and 0 during an erase. Every bit except bits 7 and 6 is 0.
- R6: Bit 6 of the status word inverts on each busy read. The first read accepted after `readyN` returns to 1 yields array data.
- R7: An erase-suspend (`cmdOp`=4) accepted during the preprogram or pulse phase drives `readyN` to 1 in the next cycle. While suspended, reads of sectors outside the erase return array data. Reads of erased sectors return bit 7 = 1 with bit 6 held still.
- R8: An erase-resume (`cmdOp`=5) continues the erase from where it stopped, so the total count of busy cycles equals that of an uninterrupted erase.
- R9: A program or erase aimed at a sector whose `protMask` bit is 1 is ignored, or that sector is excluded from the erase, unless `unprotect` is 1.
- R10: While `lowVcc` is 1, no program or erase starts.
- R11: While busy, commands other than an erase-suspend during an erase are ignored. While suspended, commands other than resume are ignored.
- R12: A synchronous reset during an operation aborts it. `readyN` is 1 in the next cycle, and a program aborted in its pulse phase leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, aborts any operation |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 3 | 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume |
| cmdAddr | input | ADDR_W | Program word address |
| cmdData | input | DATA_W | Program data |
| cmdSectMask | input | SECT_N | Sector select for sector erase |
| protMask | input | SECT_N | Per-sector write protection |
| unprotect | input | 1 | Temporary override of protection |
| lowVcc | input | 1 | Low-supply inhibit |
| rdEn | input | 1 | Host read request |
| rdAddr | input | ADDR_W | Host read address |
| rdData | output | DATA_W | Read data or status word, valid one cycle after rdEn |
| readyN | output | 1 | 1 ready, 0 busy |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a host read and the last busy cycle: the bench reads on every cycle of every operation, so one read always falls on the verify cycle. That read must still return status, and the read after it must return data. The second pair is a suspend and the final erase-pulse cycle: the suspend is provoked there as a directed case, as well as at the first cycle and in the middle of the preprogram scan. In each case the busy cycles before the suspend and after the resume must add up to the uninterrupted erase length.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_SERASE  = 3'd2,
    OP_CERASE  = 3'd3,
    OP_SUSPEND = 3'd4,
    OP_RESUME  = 3'd5
  } cmdOp_e;

  // Strobes from the sequencer to the array datapath
  typedef struct packed {
    logic progWr;     // AND program data into the latched word
    logic preScan;    // preprogram the scanned word if it is selected and not zero
    logic eraseWr;    // set all selected sectors to ones
    logic progCheck;  // program verify cycle
    logic eraseCheck; // erase verify cycle
    logic busyRead;   // host reads return toggling status
    logic suspRead;   // erase suspended: erased sectors return frozen status
    logic pollBit7;   // value of the poll bit while busy
  } arrStrobe_t;

endpackage

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_op_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SECT_N    = 4,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [SECT_N-1:0] cmdSectMask,
  input  logic [SECT_N-1:0] protMask,
  input  logic              unprotect,
  input  logic              lowVcc,
  output arrStrobe_t        strobe,
  output logic [ADDR_W-1:0] opAddr,
  output logic [ADDR_W-1:0] scanAddr,
  output logic [DATA_W-1:0] opData,
  output logic [SECT_N-1:0] eraseMask,
  output logic              readyN
);

  localparam int SECT_W  = $clog2(SECT_N);
  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  typedef enum logic [3:0] {
    S_IDLE, S_PPULSE, S_PWRITE, S_PVERIFY,
    S_EPRE, S_EPULSE, S_EWRITE, S_EVERIFY, S_SUSP
  } seqState_e;

  seqState_e         state, resumeState, advState;
  logic [CNT_W-1:0]  cnt, advCnt;
  logic [ADDR_W-1:0] advScan;
  logic              isProg;

  function automatic logic [SECT_W-1:0] sectOf(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  // Request qualification
  logic [SECT_N-1:0] lockMask, reqMask, effMask;
  logic progReq, eraseReq, suspendReq, resumeReq, progOk, eraseOk;

  always_comb begin
    lockMask   = unprotect ? '0 : protMask;
    progReq    = cmdValid && (cmdOp == OP_PROG);
    eraseReq   = cmdValid && ((cmdOp == OP_SERASE) || (cmdOp == OP_CERASE));
    suspendReq = cmdValid && (cmdOp == OP_SUSPEND);
    resumeReq  = cmdValid && (cmdOp == OP_RESUME);
    reqMask    = (cmdOp == OP_CERASE) ? '1 : cmdSectMask;
    effMask    = reqMask & ~lockMask;
    progOk     = !lowVcc && !lockMask[sectOf(cmdAddr)];
    eraseOk    = !lowVcc && (|effMask);
  end

  // One step of the suspendable erase phases
  always_comb begin
    advState = state;
    advCnt   = cnt;
    advScan  = scanAddr;
    case (state)
      S_EPRE: begin
        if (scanAddr == LAST_ADDR) begin
          advState = S_EPULSE;
          advCnt   = CNT_W'(ERASE_CYC - 1);
          advScan  = '0;
        end else begin
          advScan = scanAddr + 1'b1;
        end
      end
      S_EPULSE: begin
        if (cnt == '0) advState = S_EWRITE;
        else           advCnt   = cnt - 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      resumeState <= S_IDLE;
      cnt         <= '0;
      scanAddr    <= '0;
      opAddr      <= '0;
      opData      <= '0;
      eraseMask   <= '0;
      isProg      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (progReq && progOk) begin
            opAddr <= cmdAddr;
            opData <= cmdData;
            cnt    <= CNT_W'(PROG_CYC - 1);
            isProg <= 1'b1;
            state  <= S_PPULSE;
          end else if (eraseReq && eraseOk) begin
            eraseMask <= effMask;
            scanAddr  <= '0;
            isProg    <= 1'b0;
            state     <= S_EPRE;
          end
        end
        S_PPULSE: begin
          if (cnt == '0) state <= S_PWRITE;
          else           cnt   <= cnt - 1'b1;
        end
        S_PWRITE:  state <= S_PVERIFY;
        S_PVERIFY: state <= S_IDLE;
        S_EPRE, S_EPULSE: begin
          cnt         <= advCnt;
          scanAddr    <= advScan;
          resumeState <= advState;
          state       <= suspendReq ? S_SUSP : advState;
        end
        S_EWRITE:  state <= S_EVERIFY;
        S_EVERIFY: state <= S_IDLE;
        S_SUSP: begin
          if (resumeReq) state <= resumeState;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic busy;
  always_comb begin
    busy              = (state != S_IDLE) && (state != S_SUSP);
    readyN            = !busy;
    strobe.progWr     = (state == S_PWRITE);
    strobe.preScan    = (state == S_EPRE);
    strobe.eraseWr    = (state == S_EWRITE);
    strobe.progCheck  = (state == S_PVERIFY);
    strobe.eraseCheck = (state == S_EVERIFY);
    strobe.busyRead   = busy;
    strobe.suspRead   = (state == S_SUSP);
    strobe.pollBit7   = isProg ? ~opData[7] : 1'b0;
  end

  // R10
  lowvcc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && lowVcc) |=> (state == S_IDLE));

  // R9
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && progReq && lockMask[sectOf(cmdAddr)]) |=> (state == S_IDLE));

  // R8
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUSP) |=> ($stable(cnt) && $stable(scanAddr)));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PPULSE && cmdValid) |=> ($stable(opAddr) && $stable(opData)));

  // R7
  susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_EPRE || state == S_EPULSE) && suspendReq) |=> readyN);

endmodule

// File: rtl/flash_op_array.sv
module flash_op_array
  import flash_op_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SECT_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  arrStrobe_t        strobe,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [ADDR_W-1:0] scanAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [SECT_N-1:0] eraseMask,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int SECT_W  = $clog2(SECT_N);
  localparam int SECT_SH = ADDR_W - SECT_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              toggleQ;

  function automatic logic [SECT_W-1:0] sectOf(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  function automatic logic [SECT_W-1:0] sectOfIdx(input int w);
    return SECT_W'(w >> SECT_SH);
  endfunction

  function automatic logic [DATA_W-1:0] statWord(input logic b7, input logic b6);
    logic [DATA_W-1:0] s;
    s    = '0;
    s[7] = b7;
    s[6] = b6;
    return s;
  endfunction

  logic [DATA_W-1:0] scanWord;
  logic              scanSel;
  assign scanWord = mem[scanAddr];
  assign scanSel  = eraseMask[sectOf(scanAddr)];

  // Array writes: bulk erase, preprogram, program (only 1->0)
  always_ff @(posedge clk) begin
    if (strobe.eraseWr) begin
      for (int w = 0; w < DEPTH; w++) begin
        if (eraseMask[sectOfIdx(w)]) mem[w] <= '1;
      end
    end
    if (strobe.preScan && scanSel && (scanWord != '0)) mem[scanAddr] <= '0;
    if (strobe.progWr) mem[opAddr] <= mem[opAddr] & opData;
  end

  // Host read port with status substitution
  logic [SECT_W-1:0] rdSect;
  assign rdSect = sectOf(rdAddr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData  <= '0;
      toggleQ <= 1'b0;
    end else if (rdEn) begin
      if (strobe.busyRead) begin
        rdData  <= statWord(strobe.pollBit7, toggleQ);
        toggleQ <= ~toggleQ;
      end else if (strobe.suspRead && eraseMask[rdSect]) begin
        rdData <= statWord(1'b1, toggleQ);
      end else begin
        rdData <= mem[rdAddr];
      end
    end
  end

  // Verify results
  logic progGood, eraseGood;
  always_comb begin
    progGood  = ((mem[opAddr] & ~opData) == '0);
    eraseGood = 1'b1;
    for (int w = 0; w < DEPTH; w++) begin
      if (eraseMask[sectOfIdx(w)] && (mem[w] != '1)) eraseGood = 1'b0;
    end
  end

  // R2
  prog_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.progCheck |-> progGood);

  // R3
  erase_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.eraseCheck |-> eraseGood);

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && strobe.busyRead && $past(rdEn && strobe.busyRead))
      |=> (rdData[6] != $past(rdData[6])));

  // R7
  susp_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && strobe.suspRead && eraseMask[rdSect]) |=> rdData[7]);

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_op_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SECT_N    = 4,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [SECT_N-1:0] cmdSectMask,
  input  logic [SECT_N-1:0] protMask,
  input  logic              unprotect,
  input  logic              lowVcc,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              readyN
);

  arrStrobe_t        strobe;
  logic [ADDR_W-1:0] opAddr, scanAddr;
  logic [DATA_W-1:0] opData;
  logic [SECT_N-1:0] eraseMask;

  flash_op_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_N(SECT_N),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdSectMask(cmdSectMask),
    .protMask(protMask), .unprotect(unprotect), .lowVcc(lowVcc),
    .strobe(strobe), .opAddr(opAddr), .scanAddr(scanAddr), .opData(opData),
    .eraseMask(eraseMask), .readyN(readyN)
  );

  flash_op_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_N(SECT_N)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opAddr(opAddr),
    .scanAddr(scanAddr), .opData(opData), .eraseMask(eraseMask),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: tb/tb_flash_op_engine.sv
module tb_flash_op_engine;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int SECT_N     = 4;
  localparam int PROG_CYC   = 4;
  localparam int ERASE_CYC  = 8;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int SECT_SH    = ADDR_W - $clog2(SECT_N);
  localparam int PROG_BUSY  = PROG_CYC + 2;
  localparam int ERASE_BUSY = DEPTH + ERASE_CYC + 2;

  localparam logic [2:0] C_PROG = 3'd1, C_SERASE = 3'd2, C_CERASE = 3'd3,
                         C_SUSP = 3'd4, C_RES = 3'd5;

  logic clk = 1'b0;
  logic rst_n, cmdValid, unprotect, lowVcc, rdEn, readyN;
  logic [2:0] cmdOp;
  logic [ADDR_W-1:0] cmdAddr, rdAddr;
  logic [DATA_W-1:0] cmdData, rdData;
  logic [SECT_N-1:0] cmdSectMask, protMask;

  logic [DATA_W-1:0] model [DEPTH];
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_op_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_N(SECT_N),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdSectMask(cmdSectMask),
    .protMask(protMask), .unprotect(unprotect), .lowVcc(lowVcc),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .readyN(readyN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sectOf(input logic [ADDR_W-1:0] a);
    return int'(a >> SECT_SH);
  endfunction

  function automatic logic [SECT_N-1:0] lockOf();
    return unprotect ? '0 : protMask;
  endfunction

  function automatic int expProgBusy(input logic [ADDR_W-1:0] a);
    return (lowVcc || lockOf()[sectOf(a)]) ? 0 : PROG_BUSY;
  endfunction

  function automatic logic [SECT_N-1:0] effErase(input logic [2:0] op, input logic [SECT_N-1:0] m);
    logic [SECT_N-1:0] r;
    r = (op == C_CERASE) ? '1 : m;
    return lowVcc ? '0 : (r & ~lockOf());
  endfunction

  task automatic modelErase(input logic [SECT_N-1:0] m);
    for (int w = 0; w < DEPTH; w++)
      if (m[sectOf(ADDR_W'(w))]) model[w] = '1;
  endtask

  task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [SECT_N-1:0] m);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d; cmdSectMask = m;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0;
  endtask

  // Drive a command in the current cycle, counting it if the block is busy
  task automatic poke(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [SECT_N-1:0] m,
                      inout int n);
    if (!readyN) n++;
    issue(op, a, d, m);
  endtask

  task automatic readWord(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  // Read every cycle while busy; stop after limit busy cycles (limit<0: until done)
  task automatic runBusy(input int limit, input bit isProg, input logic [DATA_W-1:0] pd,
                         inout int n, output bit done);
    bit havePrev = 1'b0;
    logic prevT = 1'b0;
    done = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] ra;
      ra = ADDR_W'($urandom_range(DEPTH - 1));
      if (readyN) begin
        rdEn = 1'b1; rdAddr = ra;
        @(negedge clk);
        rdEn = 1'b0;
        // R6: first read after completion returns data
        chk(rdData == model[ra], "R6 data after done", int'(rdData), int'(model[ra]));
        done = 1'b1;
        return;
      end
      if (limit >= 0 && n >= limit) begin
        rdEn = 1'b0;
        return;
      end
      rdEn = 1'b1; rdAddr = ra;
      @(negedge clk);
      n++;
      // R5: poll bit and zero fields
      chk(rdData[7] == (isProg ? ~pd[7] : 1'b0) && rdData[5:0] == 6'd0,
          "R5 status word", int'(rdData), int'({isProg ? ~pd[7] : 1'b0, 7'd0}));
      if (havePrev) chk(rdData[6] != prevT, "R6 toggle", int'(rdData[6]), int'(~prevT));
      prevT = rdData[6];
      havePrev = 1'b1;
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [SECT_N-1:0] m,
                       input string req);
    int n = 0;
    int expBusy;
    bit done;
    logic [SECT_N-1:0] em;
    if (op == C_PROG) begin
      expBusy = expProgBusy(a);
      if (expBusy != 0) model[a] = model[a] & d;
    end else begin
      em = effErase(op, m);
      expBusy = (em == '0) ? 0 : ERASE_BUSY;
      modelErase(em);
    end
    issue(op, a, d, m);
    runBusy(-1, op == C_PROG, d, n, done);
    chk(n == expBusy, req, n, expBusy);
  endtask

  task automatic dumpCheck(input string req);
    int bad = 0;
    logic [DATA_W-1:0] v;
    for (int w = 0; w < DEPTH; w++) begin
      readWord(ADDR_W'(w), v);
      if (v != model[w]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic suspendCase(input int k);
    int n = 0;
    bit done;
    logic [DATA_W-1:0] v1, v2;
    issue(C_SERASE, '0, '0, 4'b0001);
    runBusy(k, 1'b0, '0, n, done);
    poke(C_SUSP, '0, '0, '0, n);
    // R7: ready while suspended
    chk(readyN == 1'b1, "R7 ready in suspend", int'(readyN), 1);
    readWord(6'h30, v1);
    chk(v1 == model[6'h30], "R7 read other sector", int'(v1), int'(model[6'h30]));
    readWord(6'h03, v1);
    readWord(6'h03, v2);
    chk(v1[7] && v2[7] && v1[6] == v2[6] && v1[5:0] == 0, "R7 frozen status",
        int'(v2), int'({1'b1, v1[6], 6'd0}));
    // R11: program while suspended is ignored
    issue(C_PROG, 6'h30, 8'h00, '0);
    chk(readyN == 1'b1, "R11 suspended ignores program", int'(readyN), 1);
    readWord(6'h30, v1);
    chk(v1 == model[6'h30], "R11 word kept", int'(v1), int'(model[6'h30]));
    modelErase(4'b0001);
    issue(C_RES, '0, '0, '0);
    chk(readyN == 1'b0, "R8 busy after resume", int'(readyN), 0);
    runBusy(-1, 1'b0, '0, n, done);
    // R8: progress preserved across suspension
    chk(n == ERASE_BUSY, "R8 total busy", n, ERASE_BUSY);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    int n;
    bit done;
    void'($urandom(32'h5eed_f1a5));
    rst_n = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdAddr = '0; cmdData = '0;
    cmdSectMask = '0; protMask = '0; unprotect = 1'b0; lowVcc = 1'b0;
    rdEn = 1'b0; rdAddr = '0;
    for (int w = 0; w < DEPTH; w++) model[w] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(readyN == 1'b1, "R1 ready after reset", int'(readyN), 1);

    runOp(C_CERASE, '0, '0, '0, "R4 chip erase busy");
    dumpCheck("R4 chip erase all ones");
    readWord(6'h2A, v);
    chk(v == 8'hFF, "R1 read returns array", int'(v), 8'hFF);

    runOp(C_PROG, 6'h05, 8'h3C, '0, "R2 program busy");
    readWord(6'h05, v);
    chk(v == 8'h3C, "R2 program value", int'(v), 8'h3C);
    runOp(C_PROG, 6'h05, 8'hF0, '0, "R2 reprogram busy");
    readWord(6'h05, v);
    chk(v == 8'h30, "R2 AND only clears", int'(v), 8'h30);

    // R9: protection and override
    protMask = 4'b0010;
    runOp(C_PROG, 6'h12, 8'h00, '0, "R9 protected program ignored");
    readWord(6'h12, v);
    chk(v == 8'hFF, "R9 protected word kept", int'(v), 8'hFF);
    unprotect = 1'b1;
    runOp(C_PROG, 6'h12, 8'h5A, '0, "R9 unprotect program busy");
    unprotect = 1'b0;
    runOp(C_PROG, 6'h02, 8'h11, '0, "R2 program sector0");
    runOp(C_CERASE, '0, '0, '0, "R9 chip erase with protected sector");
    readWord(6'h12, v);
    chk(v == 8'h5A, "R9 protected sector kept", int'(v), 8'h5A);
    readWord(6'h02, v);
    chk(v == 8'hFF, "R4 other sector erased", int'(v), 8'hFF);
    protMask = 4'b1111;
    runOp(C_SERASE, '0, '0, 4'b0010, "R9 erase of protected only ignored");
    protMask = '0;

    // R10: low supply
    lowVcc = 1'b1;
    runOp(C_PROG, 6'h07, 8'h00, '0, "R10 low supply program ignored");
    runOp(C_CERASE, '0, '0, '0, "R10 low supply erase ignored");
    lowVcc = 1'b0;
    readWord(6'h07, v);
    chk(v == model[6'h07], "R10 word kept", int'(v), int'(model[6'h07]));

    // R11: commands during program ignored
    runOp(C_PROG, 6'h20, 8'h11, '0, "R2 program sector2");
    n = 0;
    model[6'h07] = model[6'h07] & 8'h55;
    issue(C_PROG, 6'h07, 8'h55, '0);
    runBusy(2, 1'b1, 8'h55, n, done);
    poke(C_CERASE, '0, '0, '0, n);
    poke(C_SUSP, '0, '0, '0, n);
    runBusy(-1, 1'b1, 8'h55, n, done);
    chk(n == PROG_BUSY, "R11 busy unaffected by commands", n, PROG_BUSY);
    readWord(6'h20, v);
    chk(v == 8'h11, "R11 no erase started", int'(v), 8'h11);

    // R7, R8: suspend at start, mid scan, and last pulse cycle
    runOp(C_PROG, 6'h30, 8'h42, '0, "R2 program sector3");
    runOp(C_PROG, 6'h03, 8'h0F, '0, "R2 program sector0");
    suspendCase(0);
    runOp(C_PROG, 6'h03, 8'h0F, '0, "R2 program sector0");
    suspendCase(DEPTH / 2);
    runOp(C_PROG, 6'h03, 8'h0F, '0, "R2 program sector0");
    suspendCase(DEPTH + ERASE_CYC - 1);
    readWord(6'h03, v);
    chk(v == 8'hFF, "R3 erased word", int'(v), 8'hFF);

    // R12: reset aborts a program in its pulse phase
    n = 0;
    issue(C_PROG, 6'h30, 8'h00, '0);
    runBusy(2, 1'b1, 8'h00, n, done);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(readyN == 1'b1, "R12 ready after abort", int'(readyN), 1);
    readWord(6'h30, v);
    chk(v == 8'h42, "R12 word unchanged", int'(v), 8'h42);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      int sel;
      sel = int'($urandom_range(99));
      protMask  = SECT_N'($urandom);
      unprotect = ($urandom_range(4) == 0);
      lowVcc    = ($urandom_range(9) == 0);
      if (sel < 70)
        runOp(C_PROG, ADDR_W'($urandom), DATA_W'($urandom), '0, "R2 random program");
      else if (sel < 92)
        runOp(C_SERASE, '0, '0, SECT_N'($urandom), "R3 random sector erase");
      else
        runOp(C_CERASE, '0, '0, '0, "R4 random chip erase");
    end
    protMask = '0; unprotect = 1'b0; lowVcc = 1'b0;
    dumpCheck("R3 final array contents");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule